// File: doc/BRIEF.md
# Accumulator ALU with Per-Flag Write Enables

This block is the arithmetic and logic stage of a small accumulator-style microcontroller core. It has 8-bit data. One operand comes from the working register W and one from the register file. The block also takes the incoming carry, digit-carry and zero bits and a carry-extend mode bit. It returns a result, a destination choice and a three-bit status field. Each status bit has its own write enable. A bit whose enable is low carries its incoming value through unchanged. This lets the core's status register be written without any read-modify-write logic.

Each operation has its own rule for which flags it may touch. Subtraction is always the register operand minus W. Carry acts as an inverted borrow, so a compare-and-skip sequence can take its decision straight from C and Z. Carry-extend mode decides whether add and subtract consume the incoming carry, which makes multi-byte arithmetic possible.

A request is accepted on a clock edge where `valid_i` is high. Its results are registered and appear on the following cycle.

Top module: `alu8_core`

## Requirements
- R1: A request with `valid_i` high and a defined code (0 to 13) gives `valid_o` high on the next cycle. When `valid_o` is low, all write enables are low. Reset drives `valid_o`, `res_o` and `flag_we_o` to zero.
- R2: Add (code 2) returns f+w, plus C when carry-extend is on. It writes C (carry out of bit 7), DC (carry out of bit 3) and Z. When carry-extend is off, the incoming C is ignored.
- R3: Subtract (code 3) returns f−w, minus the inverse of C when carry-extend is on. C=1 means no borrow, so f≥w in plain mode. DC=1 means no borrow out of bit 3. Z=1 means the result is zero. All three flags are written.
- R4: AND (4), OR (5), XOR (6), clear (7, result 0), increment of f (8), decrement of f (9) and complement of f (10) write only Z. Z is set exactly when the result is zero.
- R5: Rotate left (11) and rotate right (12) shift f through carry. The bit that leaves goes to C, the old C enters the vacated end, and only C is written.
- R6: Swap (13) exchanges the two nibbles of f and writes no flag.
- R7: Move register (0) returns f and writes only Z. Move W (1) returns w, forces the destination to the register (`dst_w_o`=0) and writes no flag.
- R8: `flags_o` holds C at bit 0, DC at bit 1 and Z at bit 2. Every bit whose enable in `flag_we_o` (same positions) is low equals the `flags_i` bit of that request.
- R9: For every defined code except 1, `dst_w_o` equals `dest_w_i` of the request (1 = W, 0 = register).
- R10: A request with code 14 or 15 is dropped. `valid_o` stays low on the next cycle and no flag enable is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request present this cycle |
| op_i | input | 4 | Operation code |
| w_i | input | 8 | W operand |
| f_i | input | 8 | Register-file operand |
| flags_i | input | 3 | Incoming {Z, DC, C} |
| carry_ext_i | input | 1 | Add/subtract consume incoming carry |
| dest_w_i | input | 1 | Destination select, 1 = W |
| valid_o | output | 1 | Result present |
| res_o | output | 8 | Result |
| dst_w_o | output | 1 | Result goes to W when 1 |
| flags_o | output | 3 | Resulting {Z, DC, C} |
| flag_we_o | output | 3 | Per-flag write enables, same positions |

## Verification
Every output of a request is due exactly one cycle after the rising edge that accepted it, because the block has a single register stage. The driver applies a request or an idle slot on every falling edge and queues one expected entry for each slot. The monitor samples shortly after each rising edge and removes one entry per cycle. Idle slots and dropped codes are therefore checked as cycles with no result, in the same order in which they were driven.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_MOVF = 4'd0,
    OP_MOVW = 4'd1,
    OP_ADD  = 4'd2,
    OP_SUB  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_CLR  = 4'd7,
    OP_INC  = 4'd8,
    OP_DEC  = 4'd9,
    OP_NOT  = 4'd10,
    OP_RL   = 4'd11,
    OP_RR   = 4'd12,
    OP_SWAP = 4'd13
  } alu_op_e;

  localparam int unsigned OP_LAST = 13;
  localparam int unsigned NFLAG   = 3;
  localparam int unsigned FL_C    = 0;
  localparam int unsigned FL_DC   = 1;
  localparam int unsigned FL_Z    = 2;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sub_i,
  input  logic          cx_i,
  input  logic          c_i,
  output logic [DW-1:0] sum_o,
  output logic          c_o,
  output logic          dc_o
);
  localparam int unsigned NW = DW / 2;
  localparam int unsigned HW = DW - NW;

  logic [DW-1:0] b_eff;
  logic          cin;
  logic [NW:0]   lo;
  logic [HW:0]   hi;

  // a - b == a + ~b + 1; extended borrow folds into the carry-in
  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    cin   = cx_i ? c_i : sub_i;
    lo    = {1'b0, a_i[NW-1:0]} + {1'b0, b_eff[NW-1:0]} + {{NW{1'b0}}, cin};
    hi    = {1'b0, a_i[DW-1:NW]} + {1'b0, b_eff[DW-1:NW]} + {{HW{1'b0}}, lo[NW]};
    sum_o = {hi[HW-1:0], lo[NW-1:0]};
    c_o   = hi[HW];
    dc_o  = lo[NW];
  end
endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
  import alu8_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] w_i,
  input  logic [DW-1:0] f_i,
  output logic [DW-1:0] res_o
);
  localparam logic [DW-1:0] ONE = DW'(1);

  always_comb begin
    case (op_i)
      OP_AND:  res_o = f_i & w_i;
      OP_OR:   res_o = f_i | w_i;
      OP_XOR:  res_o = f_i ^ w_i;
      OP_CLR:  res_o = '0;
      OP_INC:  res_o = f_i + ONE;
      OP_DEC:  res_o = f_i - ONE;
      OP_NOT:  res_o = ~f_i;
      default: res_o = f_i;
    endcase
  end
endmodule

// File: rtl/alu8_rotate.sv
module alu8_rotate
  import alu8_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] f_i,
  input  logic          c_i,
  output logic [DW-1:0] res_o,
  output logic          c_o
);
  localparam int unsigned NW = DW / 2;

  always_comb begin
    res_o = f_i;
    c_o   = c_i;
    case (op_i)
      OP_RL: begin
        res_o = {f_i[DW-2:0], c_i};
        c_o   = f_i[DW-1];
      end
      OP_RR: begin
        res_o = {c_i, f_i[DW-1:1]};
        c_o   = f_i[0];
      end
      OP_SWAP: res_o = {f_i[NW-1:0], f_i[DW-1:NW]};
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [3:0]       op_i,
  input  logic [DW-1:0]    w_i,
  input  logic [DW-1:0]    f_i,
  input  logic [NFLAG-1:0] flags_i,
  input  logic             carry_ext_i,
  input  logic             dest_w_i,
  output logic             valid_o,
  output logic [DW-1:0]    res_o,
  output logic             dst_w_o,
  output logic [NFLAG-1:0] flags_o,
  output logic [NFLAG-1:0] flag_we_o
);
  alu_op_e          op;
  logic             known;
  logic [DW-1:0]    as_sum, bw_res, rt_res, nxt_res;
  logic             as_c, as_dc, rt_c, nxt_dst;
  logic [NFLAG-1:0] nxt_we, nxt_val, nxt_flags;

  assign op    = alu_op_e'(op_i);
  assign known = (32'(op_i) <= OP_LAST);

  alu8_addsub #(.DW(DW)) u_addsub (
    .a_i  (f_i),
    .b_i  (w_i),
    .sub_i(op == OP_SUB),
    .cx_i (carry_ext_i),
    .c_i  (flags_i[FL_C]),
    .sum_o(as_sum),
    .c_o  (as_c),
    .dc_o (as_dc)
  );

  alu8_bitwise #(.DW(DW)) u_bitwise (
    .op_i (op),
    .w_i  (w_i),
    .f_i  (f_i),
    .res_o(bw_res)
  );

  alu8_rotate #(.DW(DW)) u_rotate (
    .op_i (op),
    .f_i  (f_i),
    .c_i  (flags_i[FL_C]),
    .res_o(rt_res),
    .c_o  (rt_c)
  );

  always_comb begin
    nxt_res = bw_res;
    nxt_dst = dest_w_i;
    nxt_we  = '0;
    nxt_val = flags_i;
    case (op)
      OP_ADD, OP_SUB: begin
        nxt_res        = as_sum;
        nxt_we         = '1;
        nxt_val[FL_C]  = as_c;
        nxt_val[FL_DC] = as_dc;
      end
      OP_MOVW: begin
        nxt_res = w_i;
        nxt_dst = 1'b0;
      end
      OP_RL, OP_RR: begin
        nxt_res       = rt_res;
        nxt_we[FL_C]  = 1'b1;
        nxt_val[FL_C] = rt_c;
      end
      OP_SWAP: nxt_res = rt_res;
      OP_MOVF, OP_AND, OP_OR, OP_XOR, OP_CLR, OP_INC, OP_DEC, OP_NOT:
        nxt_we[FL_Z] = 1'b1;
      default: ;
    endcase
    nxt_val[FL_Z] = (nxt_res == '0);
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_merge
    assign nxt_flags[i] = nxt_we[i] ? nxt_val[i] : flags_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      res_o     <= '0;
      dst_w_o   <= 1'b0;
      flags_o   <= '0;
      flag_we_o <= '0;
    end else begin
      valid_o <= valid_i & known;
      if (valid_i && known) begin
        res_o     <= nxt_res;
        dst_w_o   <= nxt_dst;
        flags_o   <= nxt_flags;
        flag_we_o <= nxt_we;
      end else begin
        flag_we_o <= '0;
      end
    end
  end
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [3:0]       op_i,
  input logic [DW-1:0]    w_i,
  input logic [DW-1:0]    f_i,
  input logic [NFLAG-1:0] flags_i,
  input logic             dest_w_i,
  input logic             valid_o,
  input logic [DW-1:0]    res_o,
  input logic             dst_w_o,
  input logic [NFLAG-1:0] flags_o,
  input logic [NFLAG-1:0] flag_we_o
);
  localparam int unsigned NW = DW / 2;

  a_r1_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i <= OP_SWAP |=> valid_o);

  a_r1_idle_no_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> flag_we_o == '0);

  a_r10_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i > OP_SWAP |=> !valid_o);

  a_r4_z_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i >= OP_AND && op_i <= OP_NOT |=> flag_we_o == 3'b100);

  a_r4_z_from_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && flag_we_o[FL_Z] |-> flags_o[FL_Z] == (res_o == '0));

  a_r5_c_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == OP_RL || op_i == OP_RR) |=> flag_we_o == 3'b001);

  a_r6_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_SWAP |=>
      flag_we_o == '0 && res_o == {$past(f_i[NW-1:0]), $past(f_i[DW-1:NW])});

  a_r7_move_w: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_MOVW |=>
      !dst_w_o && flag_we_o == '0 && res_o == $past(w_i));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i <= OP_SWAP |=> ((~flag_we_o) & (flags_o ^ $past(flags_i))) == '0);

  a_r9_dest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i <= OP_SWAP && op_i != OP_MOVW |=> dst_w_o == $past(dest_w_i));
endmodule

bind alu8_core alu8_core_chk #(.DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .op_i     (op_i),
  .w_i      (w_i),
  .f_i      (f_i),
  .flags_i  (flags_i),
  .dest_w_i (dest_w_i),
  .valid_o  (valid_o),
  .res_o    (res_o),
  .dst_w_o  (dst_w_o),
  .flags_o  (flags_o),
  .flag_we_o(flag_we_o)
);

// File: tb/sim_alu8_core.sv
module sim_alu8_core;
  typedef struct packed {
    logic       v;
    logic [7:0] r;
    logic       d;
    logic [2:0] fl;
    logic [2:0] we;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid_i = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] w_i = '0, f_i = '0;
  logic [2:0] flags_i = '0;
  logic       carry_ext_i = 1'b0, dest_w_i = 1'b0;
  logic       valid_o, dst_w_o;
  logic [7:0] res_o;
  logic [2:0] flags_o, flag_we_o;

  int   total = 0, bad = 0;
  bit   done = 0;
  exp_t q[$];
  string tq[$];

  always #4 clk = ~clk;

  alu8_core u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i),
    .w_i(w_i), .f_i(f_i), .flags_i(flags_i), .carry_ext_i(carry_ext_i),
    .dest_w_i(dest_w_i), .valid_o(valid_o), .res_o(res_o), .dst_w_o(dst_w_o),
    .flags_o(flags_o), .flag_we_o(flag_we_o)
  );

  function automatic exp_t model(int op, int w, int f, logic [2:0] fl, logic cx, logic dw);
    exp_t e;
    int r, ci;
    logic c, dc, z;
    logic [2:0] we;
    e = '0; e.v = 1'b1; e.d = dw;
    c = fl[0]; dc = fl[1]; we = 3'b000; r = f;
    case (op)
      0: we = 3'b100;
      1: begin r = w; e.d = 1'b0; end
      2: begin
        ci = (cx && fl[0]) ? 1 : 0;
        r = f + w + ci; c = (r > 255); dc = ((f % 16) + (w % 16) + ci) > 15; we = 3'b111;
      end
      3: begin
        ci = (cx && !fl[0]) ? 1 : 0;
        r = f - w - ci; c = (r >= 0); dc = ((f % 16) - (w % 16) - ci) >= 0; we = 3'b111;
      end
      4: begin r = f & w; we = 3'b100; end
      5: begin r = f | w; we = 3'b100; end
      6: begin r = f ^ w; we = 3'b100; end
      7: begin r = 0; we = 3'b100; end
      8: begin r = f + 1; we = 3'b100; end
      9: begin r = f - 1; we = 3'b100; end
      10: begin r = 255 - f; we = 3'b100; end
      11: begin r = (f * 2) % 256 + (fl[0] ? 1 : 0); c = (f >= 128); we = 3'b001; end
      12: begin r = f / 2 + (fl[0] ? 128 : 0); c = (f % 2) == 1; we = 3'b001; end
      13: r = (f % 16) * 16 + f / 16;
      default: e.v = 1'b0;
    endcase
    r = r & 255;
    z = (r == 0);
    e.r = r[7:0];
    e.we = e.v ? we : 3'b000;
    e.fl = {we[2] ? z : fl[2], we[1] ? dc : fl[1], we[0] ? c : fl[0]};
    return e;
  endfunction

  task automatic check(bit ok, string tag, logic [15:0] act, logic [15:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic issue(int op, int w, int f, logic [2:0] fl, logic cx, logic dw, string tag);
    @(negedge clk);
    valid_i = 1'b1; op_i = op[3:0]; w_i = w[7:0]; f_i = f[7:0];
    flags_i = fl; carry_ext_i = cx; dest_w_i = dw;
    q.push_back(model(op, w, f, fl, cx, dw));
    tq.push_back(tag);
  endtask

  task automatic idle(string tag);
    exp_t e;
    @(negedge clk);
    valid_i = 1'b0; op_i = 4'd2; w_i = 8'hFF; f_i = 8'hFF;
    e = '0;
    q.push_back(e);
    tq.push_back(tag);
  endtask

  // monitor: one expected slot per cycle, sampled after the edge
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      string t;
      e = q.pop_front();
      t = tq.pop_front();
      if (e.v)
        check(valid_o && res_o == e.r && dst_w_o == e.d && flags_o == e.fl && flag_we_o == e.we,
              t, {valid_o, res_o, dst_w_o, flags_o, flag_we_o}, e);
      else
        check(!valid_o && flag_we_o == 3'b000, t,
              {valid_o, res_o, dst_w_o, flags_o, flag_we_o}, e);
    end
  end

  initial begin
    #13;
    check(!valid_o && flag_we_o == 0 && res_o == 0, "R1 reset",
          {valid_o, res_o, dst_w_o, flags_o, flag_we_o}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    // R2 add
    issue(2, 8'h07, 8'h3A, 3'b000, 1'b0, 1'b1, "R2 add nibble carry");
    issue(2, 8'h10, 8'hF0, 3'b001, 1'b0, 1'b0, "R2 add wrap, carry in ignored");
    issue(2, 8'h00, 8'h0F, 3'b001, 1'b1, 1'b1, "R2 add with carry-extend");
    issue(2, 8'hFF, 8'h00, 3'b001, 1'b1, 1'b1, "R2 add extend to zero");
    // R3 subtract f - w
    issue(3, 8'h03, 8'h05, 3'b000, 1'b0, 1'b1, "R3 sub f>w");
    issue(3, 8'h05, 8'h03, 3'b001, 1'b0, 1'b1, "R3 sub f<w borrow");
    issue(3, 8'h42, 8'h42, 3'b000, 1'b0, 1'b0, "R3 sub equal");
    issue(3, 8'h03, 8'h05, 3'b000, 1'b1, 1'b1, "R3 sub extend borrow-in");
    issue(3, 8'h03, 8'h05, 3'b000, 1'b0, 1'b1, "R3 sub plain ignores C");
    issue(3, 8'h01, 8'h10, 3'b010, 1'b0, 1'b1, "R3 sub nibble borrow");
    idle("R1 bubble");
    // R4 Z-only ops with C, DC set on entry (R8 hold)
    issue(4, 8'h0F, 8'hF0, 3'b011, 1'b0, 1'b1, "R4 and to zero");
    issue(5, 8'h0F, 8'hF0, 3'b111, 1'b0, 1'b0, "R4 or");
    issue(6, 8'h5A, 8'h5A, 3'b011, 1'b0, 1'b1, "R4 xor");
    issue(7, 8'h12, 8'h34, 3'b011, 1'b0, 1'b0, "R4 clear");
    issue(8, 8'h00, 8'hFF, 3'b011, 1'b1, 1'b1, "R4 inc wrap");
    issue(9, 8'h00, 8'h01, 3'b010, 1'b0, 1'b1, "R4 dec to zero");
    issue(10, 8'h00, 8'hFF, 3'b101, 1'b0, 1'b0, "R4 complement");
    // R5 rotates
    issue(11, 8'h00, 8'h81, 3'b110, 1'b0, 1'b1, "R5 rl out 1");
    issue(11, 8'h00, 8'h40, 3'b001, 1'b0, 1'b1, "R5 rl in 1");
    issue(12, 8'h00, 8'h01, 3'b001, 1'b0, 1'b1, "R5 rr both");
    issue(12, 8'h00, 8'h02, 3'b100, 1'b0, 1'b0, "R5 rr plain");
    // R6 swap
    issue(13, 8'h00, 8'hA5, 3'b101, 1'b0, 1'b1, "R6 swap");
    // R7 moves, R9 destination
    issue(0, 8'h99, 8'h00, 3'b011, 1'b0, 1'b1, "R7 move reg zero");
    issue(0, 8'h99, 8'h80, 3'b100, 1'b0, 1'b0, "R9 move reg to reg");
    issue(1, 8'h77, 8'h00, 3'b111, 1'b1, 1'b1, "R7 move W forces reg");
    issue(6, 8'h01, 8'h03, 3'b000, 1'b0, 1'b0, "R9 xor to reg");
    // R10 undefined codes
    issue(14, 8'h01, 8'h02, 3'b111, 1'b0, 1'b1, "R10 code 14 dropped");
    issue(15, 8'h01, 8'h02, 3'b111, 1'b0, 1'b1, "R10 code 15 dropped");
    issue(2, 8'h01, 8'h01, 3'b000, 1'b0, 1'b1, "R8 add after drop");
    idle("R1 drain");
    idle("R1 drain");
    wait (q.size() == 0);
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule